// File: doc/BRIEF.md
# Serial Command Bus Slave

This block is the host-facing serial front end of a speech and data storage controller. A host microcontroller frames each transaction by pulling an active-low select line low, then clocks in bytes most significant bit first on the rising edge of a serial clock. The first byte of every frame is an opcode. Depending on the opcode, zero, two or an open-ended stream of further bytes follow. Reply bytes go out on a separate output whose enable is low whenever no reply is being driven, so an external pad can hold the line at high impedance.

Register-style commands are committed only when select returns high: the control word is loaded, a store or play word is handed to the speech command buffers, a general reset is issued, or a status read is acknowledged. A frame that ends before all argument bytes have arrived changes nothing. Data commands stream bytes to and from a byte-wide memory port. Write streams emit one strobe per complete byte. Read streams use a request/acknowledge handshake and keep one byte fetched ahead, so each reply byte is ready before the host samples its first bit.

All serial inputs are assumed to be already synchronous to `clk`, which must run several times faster than the serial clock. The block detects serial clock edges by sampling.

Top module: `scb_slave`

## Requirements
- R1: While `csn` is low, `sdi` is sampled on each rising edge of `sclk`, most significant bit first. The first complete byte of a frame is the opcode, and later bytes are its arguments or data.
- R2: Opcode 0x01 produces, when the frame ends, a one-cycle `gen_rst` pulse and clears `ctrl_reg` to 0.
- R3: Opcode 0x60 followed by two bytes loads `ctrl_reg` with {first byte, second byte} when `csn` rises. Any further bytes are ignored, and `ctrl_reg` never changes except in the cycle after `csn` rises.
- R4: For opcode 0x61, `status_in` is captured once the opcode byte is complete. Its bit 7 is placed on `sdo` before the next sampling edge, and the following bits appear after each `sclk` rise. `sdo_oe` drops after the eighth bit. `status_rd` pulses at frame end only if all eight bits were clocked out.
- R5: Opcodes 0x62, 0x63, 0x64 and 0x65 followed by two bytes drive `spch_word` = {first, second} and pulse exactly one `spch_strobe` bit at frame end. Bit 0 is store-now (0x62), bit 1 is store-queued (0x63), bit 2 is play-now (0x64) and bit 3 is play-queued (0x65).
- R6: A frame with opcode 0x60, 0x62 to 0x65, 0x66 or 0x67 that ends with fewer than two argument bytes causes no register update, no strobe and no page load.
- R7: Opcode 0x66 pulses `wr_page_ld` with `page_addr` = {first, second} once the second byte completes. After that, every complete byte pulses `wr_byte_vld` with the byte. Opcode 0x68 streams bytes the same way without a page. A partial byte at frame end is dropped.
- R8: Opcode 0x67 pulses `rd_page_ld` with the page after two bytes and then starts a read stream. Opcode 0x69 starts a read stream at once. Bytes returned on `rd_data` with `rd_ack` are shifted out on `sdo` in arrival order, and `sdo_oe` stays high for the rest of the frame.
- R9: At most one read request is outstanding, and one byte is held ahead of the one being shifted. A read frame that clocks out k complete bytes therefore receives k+2 memory bytes.
- R10: `sdo_oe` is low from the first cycle after `csn` is seen high, and it stays low throughout write, control and speech frames.
- R11: Opcodes outside 0x01 and 0x60 to 0x69 are ignored: no strobe, no page load, no reply and no control change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from host |
| csn | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial command data |
| sdo | output | 1 | Serial reply data |
| sdo_oe | output | 1 | Reply driver enable (pad is high impedance when low) |
| ctrl_reg | output | 16 | Control word |
| gen_rst | output | 1 | General reset pulse to status and speech buffers |
| status_in | input | 8 | Status byte to report |
| status_rd | output | 1 | Pulse: status byte fully read |
| spch_word | output | 16 | Store/play word |
| spch_strobe | output | 4 | One-hot store/play command pulse |
| page_addr | output | 16 | Data start page |
| wr_page_ld | output | 1 | Pulse: load write page |
| rd_page_ld | output | 1 | Pulse: load read page |
| wr_byte | output | 8 | Byte to write |
| wr_byte_vld | output | 1 | Pulse: `wr_byte` valid |
| rd_req | output | 1 | Pulse: fetch next read byte |
| rd_ack | input | 1 | Read byte returned |
| rd_data | input | 8 | Returned read byte |

## Verification
The opcode decoder is exercised with complete frames, with frames cut short before their arguments arrive, with frames that carry surplus bytes, with frames cut mid-byte, and with an unused opcode. Together these separate the frame-end commit from an eager one and show that trailing bits are dropped. The reply path is exercised with a status byte whose bit pattern exposes bit-order and off-by-one shift errors. It is also exercised with multi-byte read streams from a memory model that answers with a delay, which shows whether the prefetch keeps each byte ready and how far the fetch pointer runs ahead. A per-cycle comparison of the control word and of the reply enable against a behavioural model catches any update or drive outside frame boundaries.

// File: rtl/scb_pkg.sv
`timescale 1ns/1ps
package scb_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    localparam logic [BYTE_W-1:0] OP_RESET   = 8'h01;
    localparam logic [BYTE_W-1:0] OP_CTRL    = 8'h60;
    localparam logic [BYTE_W-1:0] OP_STAT    = 8'h61;
    localparam logic [BYTE_W-1:0] OP_ST_NOW  = 8'h62;
    localparam logic [BYTE_W-1:0] OP_PL_Q    = 8'h65;
    localparam logic [BYTE_W-1:0] OP_WR_PG   = 8'h66;
    localparam logic [BYTE_W-1:0] OP_RD_PG   = 8'h67;
    localparam logic [BYTE_W-1:0] OP_WR_CONT = 8'h68;
    localparam logic [BYTE_W-1:0] OP_RD_CONT = 8'h69;

    localparam int ARG_BYTES = 2;
    localparam int NB_W      = 2;
    localparam int SPCH_N    = 4;
endpackage

// File: rtl/scb_rx.sv
`timescale 1ns/1ps
module scb_rx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_on,
    input  logic              sclk_rise,
    input  logic              sdi,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              vld;
    } rx_st_t;

    rx_st_t q, d;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (!frame_on) begin
            d.cnt = '0;
        end else if (sclk_rise) begin
            d.sh = {q.sh[BYTE_W-2:0], sdi};
            if (q.cnt == CNT_W'(BYTE_W - 1)) begin
                d.cnt = '0;
                d.vld = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign byte_vld = q.vld;
    assign byte_o   = q.sh;

    // R1
    rx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> $past(sclk_rise));
endmodule

// File: rtl/scb_tx.sv
`timescale 1ns/1ps
module scb_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_on,
    input  logic              sclk_rise,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              stream_on,
    input  logic              rd_ack,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_req,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              tx_idle
);
    localparam int LEFT_W = $clog2(BYTE_W + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] tx;
        logic [LEFT_W-1:0] left;
        logic [BYTE_W-1:0] pf;
        logic              pf_vld;
        logic              pend;
        logic              req;
        logic              oe;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        if (sclk_rise && q.left != '0) begin
            d.tx   = {q.tx[BYTE_W-2:0], 1'b0};
            d.left = q.left - 1'b1;
        end
        if (rd_ack) begin
            d.pend = 1'b0;
            if (stream_on) begin
                d.pf     = rd_data;
                d.pf_vld = 1'b1;
            end
        end
        if (stream_on && d.left == '0 && d.pf_vld) begin
            d.tx     = d.pf;
            d.left   = LEFT_W'(BYTE_W);
            d.pf_vld = 1'b0;
        end
        if (stream_on && !q.pend && !d.pf_vld) begin
            d.req  = 1'b1;
            d.pend = 1'b1;
        end
        if (load) begin
            d.tx   = load_byte;
            d.left = LEFT_W'(BYTE_W);
        end
        if (!frame_on) begin
            d.left   = '0;
            d.pf_vld = 1'b0;
        end
        d.oe = frame_on && (stream_on || d.left != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_req  = q.req;
    assign sdo     = q.tx[BYTE_W-1];
    assign sdo_oe  = q.oe;
    assign tx_idle = (q.left == '0);

    // R10
    oe_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> $past(frame_on));
    // R9
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
endmodule

// File: rtl/scb_slave.sv
`timescale 1ns/1ps
module scb_slave
    import scb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              csn,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_oe,
    output logic [WORD_W-1:0] ctrl_reg,
    output logic              gen_rst,
    input  logic [BYTE_W-1:0] status_in,
    output logic              status_rd,
    output logic [WORD_W-1:0] spch_word,
    output logic [SPCH_N-1:0] spch_strobe,
    output logic [WORD_W-1:0] page_addr,
    output logic              wr_page_ld,
    output logic              rd_page_ld,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              wr_byte_vld,
    output logic              rd_req,
    input  logic              rd_ack,
    input  logic [BYTE_W-1:0] rd_data
);
    localparam int IDX_W = $clog2(SPCH_N);

    typedef struct packed {
        logic              sclk_q;
        logic              csn_q;
        logic              have_cmd;
        logic [BYTE_W-1:0] cmd;
        logic [NB_W-1:0]   nb;
        logic [WORD_W-1:0] arg;
        logic [WORD_W-1:0] ctrl;
        logic              rd_on;
        logic              wr_on;
        logic              gen_rst;
        logic              stat_rd;
        logic [WORD_W-1:0] sw;
        logic [SPCH_N-1:0] strobe;
        logic [WORD_W-1:0] page;
        logic              wr_pg;
        logic              rd_pg;
        logic [BYTE_W-1:0] wrb;
        logic              wr_vld;
    } top_st_t;

    top_st_t q, d;

    logic              sclk_rise, rx_vld, load_stat, tx_idle;
    logic [BYTE_W-1:0] rx_byte;
    logic [IDX_W-1:0]  sp_idx;

    assign sclk_rise = sclk && !q.sclk_q && !csn;
    assign sp_idx    = IDX_W'(q.cmd - OP_ST_NOW);

    scb_rx #(.BYTE_W(BYTE_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .frame_on(!csn), .sclk_rise(sclk_rise),
        .sdi(sdi), .byte_vld(rx_vld), .byte_o(rx_byte)
    );

    scb_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .frame_on(!csn), .sclk_rise(sclk_rise),
        .load(load_stat), .load_byte(status_in), .stream_on(q.rd_on),
        .rd_ack(rd_ack), .rd_data(rd_data), .rd_req(rd_req),
        .sdo(sdo), .sdo_oe(sdo_oe), .tx_idle(tx_idle)
    );

    always_comb begin
        d         = q;
        d.sclk_q  = sclk;
        d.csn_q   = csn;
        d.gen_rst = 1'b0;
        d.stat_rd = 1'b0;
        d.strobe  = '0;
        d.wr_pg   = 1'b0;
        d.rd_pg   = 1'b0;
        d.wr_vld  = 1'b0;
        load_stat = 1'b0;
        if (!csn && rx_vld) begin
            if (!q.have_cmd) begin
                d.have_cmd = 1'b1;
                d.cmd      = rx_byte;
                d.nb       = '0;
                load_stat  = (rx_byte == OP_STAT);
                d.rd_on    = (rx_byte == OP_RD_CONT);
                d.wr_on    = (rx_byte == OP_WR_CONT);
            end else begin
                if (q.nb < NB_W'(ARG_BYTES)) d.arg = {q.arg[BYTE_W-1:0], rx_byte};
                if (q.nb != '1) d.nb = q.nb + 1'b1;
                if (q.nb == NB_W'(ARG_BYTES - 1) && q.cmd == OP_WR_PG) begin
                    d.page  = {q.arg[BYTE_W-1:0], rx_byte};
                    d.wr_pg = 1'b1;
                    d.wr_on = 1'b1;
                end
                if (q.nb == NB_W'(ARG_BYTES - 1) && q.cmd == OP_RD_PG) begin
                    d.page  = {q.arg[BYTE_W-1:0], rx_byte};
                    d.rd_pg = 1'b1;
                    d.rd_on = 1'b1;
                end
                if (q.wr_on) begin
                    d.wrb    = rx_byte;
                    d.wr_vld = 1'b1;
                end
            end
        end
        if (csn) begin
            d.have_cmd = 1'b0;
            d.rd_on    = 1'b0;
            d.wr_on    = 1'b0;
            d.nb       = '0;
            if (!q.csn_q && q.have_cmd) begin
                if (q.cmd == OP_RESET) begin
                    d.gen_rst = 1'b1;
                    d.ctrl    = '0;
                end else if (q.cmd == OP_CTRL && q.nb >= NB_W'(ARG_BYTES)) begin
                    d.ctrl = q.arg;
                end else if (q.cmd == OP_STAT && tx_idle) begin
                    d.stat_rd = 1'b1;
                end else if (q.cmd >= OP_ST_NOW && q.cmd <= OP_PL_Q
                             && q.nb >= NB_W'(ARG_BYTES)) begin
                    d.sw             = q.arg;
                    d.strobe[sp_idx] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.sclk_q <= 1'b1;
            q.csn_q  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ctrl_reg    = q.ctrl;
    assign gen_rst     = q.gen_rst;
    assign status_rd   = q.stat_rd;
    assign spch_word   = q.sw;
    assign spch_strobe = q.strobe;
    assign page_addr   = q.page;
    assign wr_page_ld  = q.wr_pg;
    assign rd_page_ld  = q.rd_pg;
    assign wr_byte     = q.wrb;
    assign wr_byte_vld = q.wr_vld;

    // R3
    ctrl_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_reg) |-> $past(csn && !q.csn_q));
    // R2
    rst_clears_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_rst |-> ctrl_reg == '0);
    // R5
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(spch_strobe));
    // R7
    wr_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte_vld |-> !$past(csn));
endmodule

// File: tb/tb_scb_slave.sv
`timescale 1ns/1ps
module tb_scb_slave;
    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
    logic [7:0]  status_in = 8'h00;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic        sdo, sdo_oe, gen_rst, status_rd, wr_page_ld, rd_page_ld, wr_byte_vld, rd_req;
    logic [15:0] ctrl_reg, spch_word, page_addr;
    logic [3:0]  spch_strobe;
    logic [7:0]  wr_byte;

    scb_slave dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .ctrl_reg(ctrl_reg), .gen_rst(gen_rst),
        .status_in(status_in), .status_rd(status_rd), .spch_word(spch_word),
        .spch_strobe(spch_strobe), .page_addr(page_addr), .wr_page_ld(wr_page_ld),
        .rd_page_ld(rd_page_ld), .wr_byte(wr_byte), .wr_byte_vld(wr_byte_vld),
        .rd_req(rd_req), .rd_ack(rd_ack), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    function automatic logic [7:0] memf(input int i);
        return 8'((i * 37) + 11);
    endfunction

    // memory model: answers each request two cycles later
    int rd_ptr = 0, dly = 0, ack_n = 0;
    always @(posedge clk) begin
        rd_ack <= 1'b0;
        if (rd_page_ld) rd_ptr <= int'(page_addr) * 8;
        if (rd_req) dly <= 2;
        else if (dly != 0) begin
            dly <= dly - 1;
            if (dly == 1) begin
                rd_ack  <= 1'b1;
                rd_data <= memf(rd_ptr);
                rd_ptr  <= rd_ptr + 1;
                ack_n   <= ack_n + 1;
            end
        end
    end

    // per-cycle model compare and event logs
    logic [15:0] exp_ctrl = 16'h0000, next_ctrl = 16'h0000;
    int ctrl_mism = 0, oe_mism = 0, oe_cyc = 0, gen_n = 0, strd_n = 0;
    logic csn_prev = 1'b1;
    logic [19:0] spch_q[$];
    logic [15:0] wpg_q[$], rpg_q[$];
    logic [7:0]  wb_q[$];
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (ctrl_reg !== exp_ctrl) ctrl_mism++;
            if (csn && csn_prev && sdo_oe) oe_mism++;
            csn_prev = csn;
            if (sdo_oe) oe_cyc++;
            if (gen_rst) gen_n++;
            if (status_rd) strd_n++;
            if (spch_strobe != 4'h0) spch_q.push_back({spch_strobe, spch_word});
            if (wr_page_ld) wpg_q.push_back(page_addr);
            if (rd_page_ld) rpg_q.push_back(page_addr);
            if (wr_byte_vld) wb_q.push_back(wr_byte);
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] b, output logic [7:0] r, input int nbits);
        r = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            sdi = b[i];
            tick(8);
            r[i] = sdo;
            sclk = 1'b1;
            tick(8);
            sclk = 1'b0;
        end
    endtask

    task automatic fstart;
        tick(1);
        csn = 1'b0;
        tick(8);
    endtask

    task automatic fend;
        tick(8);
        csn = 1'b1;
        exp_ctrl = next_ctrl;
        tick(12);
    endtask

    task automatic send(input logic [7:0] bs[$], input int tail);
        logic [7:0] r;
        fstart();
        foreach (bs[i]) xfer(bs[i], r, 8);
        if (tail != 0) xfer(8'hF0, r, tail);
        fend();
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0] r, r1, r2, r3;
        int n0, a0, snap, oe0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk(ctrl_reg == 16'h0 && sdo_oe == 1'b0 && rd_req == 1'b0 && spch_strobe == 4'h0,
            "reset state", {ctrl_reg, 3'b0, sdo_oe, spch_strobe}, 0);

        // R1 R3: control word, MSB-first bytes
        next_ctrl = 16'hA53C;
        send('{8'h60, 8'hA5, 8'h3C}, 0);
        chk(ctrl_reg == 16'hA53C, "R1 R3 ctrl load", ctrl_reg, 16'hA53C);
        next_ctrl = 16'h1234;
        send('{8'h60, 8'h12, 8'h34, 8'h56}, 0);
        chk(ctrl_reg == 16'h1234, "R3 extra bytes ignored", ctrl_reg, 16'h1234);
        // R6: short control frame
        send('{8'h60, 8'h77}, 0);
        chk(ctrl_reg == 16'h1234, "R6 short ctrl frame", ctrl_reg, 16'h1234);

        // R4: status read
        status_in = 8'hB6;
        n0 = strd_n;
        fstart();
        xfer(8'h61, r, 8);
        chk(sdo_oe == 1'b1 && sdo == 1'b1, "R4 bit7 ready", {sdo_oe, sdo}, 2'b11);
        xfer(8'h00, r, 8);
        chk(r == 8'hB6, "R4 status byte", r, 8'hB6);
        tick(4);
        chk(sdo_oe == 1'b0, "R4 oe after 8 bits", sdo_oe, 0);
        fend();
        chk(strd_n == n0 + 1, "R4 status_rd pulse", strd_n - n0, 1);
        fstart();
        xfer(8'h61, r, 8);
        xfer(8'h00, r, 4);
        fend();
        chk(strd_n == n0 + 1, "R4 partial status no pulse", strd_n - n0, 1);

        // R5 R6: speech words
        spch_q.delete();
        send('{8'h62, 8'h3A, 8'h05}, 0);
        send('{8'h65, 8'h80, 8'h01}, 0);
        send('{8'h64, 8'h44}, 0);
        send('{8'h63, 8'h00, 8'hFF}, 0);
        send('{8'h64, 8'hC0, 8'h0D}, 0);
        chk(spch_q.size() == 4, "R5 R6 speech strobe count", spch_q.size(), 4);
        if (spch_q.size() == 4) begin
            chk(spch_q[0] == 20'h13A05, "R5 store-now", spch_q[0], 20'h13A05);
            chk(spch_q[1] == 20'h88001, "R5 play-queued", spch_q[1], 20'h88001);
            chk(spch_q[2] == 20'h200FF, "R5 store-queued", spch_q[2], 20'h200FF);
            chk(spch_q[3] == 20'h4C00D, "R5 play-now", spch_q[3], 20'h4C00D);
        end

        // R7 R10: write streams
        oe0 = oe_cyc;
        send('{8'h66, 8'h01, 8'h23, 8'hA5, 8'h3C}, 0);
        chk(wpg_q.size() == 1 && wpg_q[0] == 16'h0123, "R7 write page",
            wpg_q.size() == 1 ? wpg_q[0] : 16'hFFFF, 16'h0123);
        send('{8'h68, 8'hC3}, 4);
        chk(wb_q.size() == 3, "R7 write byte count, partial dropped", wb_q.size(), 3);
        if (wb_q.size() == 3)
            chk(wb_q[0] == 8'hA5 && wb_q[1] == 8'h3C && wb_q[2] == 8'hC3, "R7 write bytes",
                {wb_q[0], wb_q[1], wb_q[2]}, 24'hA53CC3);
        send('{8'h66, 8'h09}, 0);
        chk(wpg_q.size() == 1, "R6 short write page frame", wpg_q.size(), 1);
        chk(oe_cyc == oe0, "R10 no reply in write frames", oe_cyc - oe0, 0);

        // R8 R9: read stream from page 2
        a0 = ack_n;
        fstart();
        xfer(8'h67, r, 8);
        xfer(8'h00, r, 8);
        xfer(8'h02, r, 8);
        xfer(8'h00, r1, 8);
        chk(sdo_oe == 1'b1, "R8 oe in stream", sdo_oe, 1);
        xfer(8'h00, r2, 8);
        xfer(8'h00, r3, 8);
        fend();
        chk(rpg_q.size() == 1 && rpg_q[0] == 16'h0002, "R8 read page", rpg_q.size(), 1);
        chk({r1, r2, r3} == {memf(16), memf(17), memf(18)}, "R8 read bytes",
            {r1, r2, r3}, {memf(16), memf(17), memf(18)});
        chk(ack_n - a0 == 5, "R9 fetch two ahead", ack_n - a0, 5);

        snap = rd_ptr;
        fstart();
        xfer(8'h69, r, 8);
        xfer(8'h00, r1, 8);
        xfer(8'h00, r2, 8);
        fend();
        chk({r1, r2} == {memf(snap), memf(snap + 1)}, "R8 read continue",
            {r1, r2}, {memf(snap), memf(snap + 1)});
        send('{8'h67, 8'h05}, 0);
        chk(rpg_q.size() == 1, "R6 short read page frame", rpg_q.size(), 1);

        // R11: unused opcode
        oe0 = oe_cyc;
        n0 = spch_q.size();
        send('{8'h7E, 8'h11, 8'h22}, 0);
        chk(spch_q.size() == n0 && wpg_q.size() == 1 && rpg_q.size() == 1 && wb_q.size() == 3
            && oe_cyc == oe0 && ctrl_reg == 16'h1234, "R11 unused opcode ignored",
            ctrl_reg, 16'h1234);

        // R2: general reset
        n0 = gen_n;
        next_ctrl = 16'h0000;
        send('{8'h01}, 0);
        chk(gen_n == n0 + 1 && ctrl_reg == 16'h0, "R2 general reset", {gen_n - n0, ctrl_reg}, 32'h10000);

        chk(ctrl_mism == 0, "R3 ctrl per-cycle model", ctrl_mism, 0);
        chk(oe_mism == 0, "R10 oe low while deselected", oe_mism, 0);
        done = 1'b1;
        summary();
    end
endmodule